// File: doc/BRIEF.md
# I2C Bus Recovery Clock Sequencer

This block clears an I2C bus on which a slave may have been left partway through a byte. That happens when the master is reset, or the slave supply is cut, while a transfer is in flight. Such a slave can hold SDA low, and it then answers the next address byte wrongly, usually with a NACK. The sequencer runs once before any normal traffic, for instance after reset or after a wake from low power once the slave supply is back. It clocks SCL by hand while leaving SDA released, so the slave can shift out the rest of its byte. It then places a STOP condition on the bus and reports completion. After that, every slave is idle and waiting for an address byte.

Both bus lines are open drain. The `*_oe_o` outputs pull a line low when they are 1, and the `*_i` inputs read the wired line level. The high half of each SCL pulse is timed only while SCL actually reads high, so a slave that stretches the clock lengthens that half. If SDA reads high at the end of a high half, the bus is free and the pulse train stops early.

The state machine has eight states. IDLE moves to CLK_LOW on start. CLK_LOW moves to CLK_HIGH after one half period. CLK_HIGH moves back to CLK_LOW after one counted half period, or to STP_PREP when that was the last pulse or SDA reads high. The STOP path then runs STP_PREP, STP_SDA_LOW, STP_SCL_UP and STP_SDA_UP, one half period each, with STP_SCL_UP counting only while SCL reads high. STP_SDA_UP moves to FINISH, and FINISH returns to IDLE after one cycle.

Top module: `i2c_unstick_seq`

## Requirements
- R1: Out of reset and whenever idle, the block pulls neither line low (scl_oe_o=0, sda_oe_o=0), and busy_o and done_o are 0.
- R2: A start_i of 1 sampled while idle makes busy_o 1 and scl_oe_o 1 in the very next cycle.
- R3: During the pulse train, every low half of SCL lasts exactly HALF_CYC cycles, and sda_oe_o stays 0 until the train has ended.
- R4: A high half is counted only in cycles where scl_i reads 1. A slave that holds SCL low for S extra cycles lengthens the whole sequence by exactly S cycles.
- R5: If SDA stays low throughout, exactly PULSES rising edges of SCL are issued before the STOP phase.
- R6: With EARLY_EXIT=1, sda_i reading 1 at the last cycle of a high half ends the train after that pulse. At least one pulse is always issued.
- R7: The STOP phase drives SCL low, then pulls SDA low, then releases SCL, then releases SDA. The bus thus sees an SDA rise while SCL is high, and the block never pulls SDA low while SCL is high.
- R8: done_o is 1 for exactly one cycle, the final cycle of busy_o, and the block is idle in the next cycle. With N pulses and S stretch cycles, done_o appears 2*N*HALF_CYC + 4*HALF_CYC + S + 1 cycles after start_i is sampled, counting the cycle of that sample as 0.
- R9: start_i is ignored while busy_o is 1. The sequence timing does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery sequence |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result follows from the number of pulses N that the bench's stuck-slave model predicts (min(M+1, PULSES) for a slave held for M clocks) and from the stretch length S. The bench therefore computes the done_o cycle as 2*N*HALF_CYC + 4*HALF_CYC + S + 1 and counts falling clock edges from the cycle start_i was sampled, so it samples exactly that cycle. R2 is sampled at the first falling edge after the start sample, and R8's return to idle at the falling edge after done_o. The bus edges (pulse count, STOP, no START, low-half lengths) are taken by a monitor that samples the wired lines at every falling clock edge and is read only after completion.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_STP_PREP,
        ST_STP_SDA_LOW,
        ST_STP_SCL_UP,
        ST_STP_SDA_UP,
        ST_FINISH
    } unstick_state_e;

endpackage

// File: rtl/i2c_unstick_halftimer.sv
// Half-period timer: counts enabled cycles, flags the last one and wraps.
module i2c_unstick_halftimer #(
    parameter int unsigned HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic expired_o
);
    localparam int unsigned CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (expired_o) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_unstick_pulsecnt.sv
// Counts finished SCL pulses; flags when the current pulse is the final one.
module i2c_unstick_pulsecnt #(
    parameter int unsigned PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] FINAL = CW'(PULSES - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q == FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_unstick_seq.sv
// Bus recovery sequencer: manual SCL pulse train, optional early exit, STOP.
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 250,
    parameter int unsigned PULSES     = 9,
    parameter bit          EARLY_EXIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o
);
    unstick_state_e state_q, state_d;

    logic half_en;
    logic half_done;
    logic last_pulse;
    logic bus_free;
    logic pulse_end;

    // Timer enable: fixed halves always count, high halves only while SCL is high.
    always_comb begin
        half_en = 1'b0;
        unique case (state_q)
            ST_CLK_LOW,
            ST_STP_PREP,
            ST_STP_SDA_LOW,
            ST_STP_SDA_UP:  half_en = 1'b1;
            ST_CLK_HIGH,
            ST_STP_SCL_UP:  half_en = scl_i;
            default:        half_en = 1'b0;
        endcase
    end

    i2c_unstick_halftimer #(
        .HALF_CYC (HALF_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (half_en),
        .expired_o (half_done)
    );

    assign pulse_end = (state_q == ST_CLK_HIGH) && half_done;

    i2c_unstick_pulsecnt #(
        .PULSES (PULSES)
    ) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q == ST_IDLE),
        .inc_i  (pulse_end),
        .last_o (last_pulse)
    );

    generate
        if (EARLY_EXIT) begin : g_early
            assign bus_free = sda_i;
        end else begin : g_full
            assign bus_free = 1'b0;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i)   state_d = ST_CLK_LOW;
            ST_CLK_LOW:     if (half_done) state_d = ST_CLK_HIGH;
            ST_CLK_HIGH: begin
                if (half_done) begin
                    state_d = (last_pulse || bus_free) ? ST_STP_PREP : ST_CLK_LOW;
                end
            end
            ST_STP_PREP:    if (half_done) state_d = ST_STP_SDA_LOW;
            ST_STP_SDA_LOW: if (half_done) state_d = ST_STP_SCL_UP;
            ST_STP_SCL_UP:  if (half_done) state_d = ST_STP_SDA_UP;
            ST_STP_SDA_UP:  if (half_done) state_d = ST_FINISH;
            ST_FINISH:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        scl_oe_o = 1'b0;
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_CLK_LOW,
            ST_STP_PREP:    scl_oe_o = 1'b1;
            ST_STP_SDA_LOW: begin
                scl_oe_o = 1'b1;
                sda_oe_o = 1'b1;
            end
            ST_STP_SCL_UP:  sda_oe_o = 1'b1;
            default: begin
                scl_oe_o = 1'b0;
                sda_oe_o = 1'b0;
            end
        endcase
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o
);
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o && !done_o));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && scl_oe_o));

    p_sda_under_low_scl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> scl_oe_o);

    p_sda_release_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> scl_i);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind i2c_unstick_seq i2c_unstick_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .scl_i    (scl_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/i2c_unstick_seq_test.sv
module i2c_unstick_seq_test;
    localparam int H = 4;
    localparam int P = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_oe, sda_oe, busy, done;
    logic hold_scl = 1'b0;
    logic hold_sda = 1'b0;
    logic scl_line, sda_line;

    int checks = 0;
    int errors = 0;

    // monitor configuration and results
    logic mon_active = 1'b0;
    int cfg_m = 0, cfg_s = 0, cfg_at = 0;
    int rises, stops, starts, first_sda, rel_idx, left, low_len, bad_low;
    bit primed, released, prev_scl, prev_sda, prev_oe, cur_scl, cur_sda;

    always #2 clk = ~clk;

    assign scl_line = !scl_oe && !hold_scl;
    assign sda_line = !sda_oe && !hold_sda;

    i2c_unstick_seq #(.HALF_CYC(H), .PULSES(P), .EARLY_EXIT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .busy_o(busy), .done_o(done)
    );

    // Bus monitor and slave model: stuck slave holds SDA until it has seen
    // cfg_m SCL rises, letting go only while SCL is low; optional stretch.
    always @(negedge clk) begin
        if (!mon_active) begin
            primed = 0; released = 0; rises = 0; stops = 0; starts = 0;
            first_sda = -1; rel_idx = 0; left = 0; low_len = 0; bad_low = 0;
            hold_scl = 1'b0; hold_sda = 1'b0;
        end else begin
            if (primed && prev_oe && !scl_oe) begin
                if (first_sda < 0 && low_len != H) bad_low++;
                low_len = 0;
                rel_idx++;
                if (rel_idx == cfg_at) left = cfg_s;
            end else if (left > 0) begin
                left--;
            end
            if (scl_oe) low_len++;
            hold_scl = (left > 0);
            cur_scl = !scl_oe && !hold_scl;
            if (!cur_scl && rises >= cfg_m) released = 1;
            hold_sda = (cfg_m > 0) && !released;
            cur_sda = !sda_oe && !hold_sda;
            if (primed) begin
                if (cur_scl && !prev_scl) rises++;
                if (cur_scl && prev_scl && cur_sda && !prev_sda) stops++;
                if (cur_scl && prev_scl && !cur_sda && prev_sda) starts++;
            end
            if (sda_oe && first_sda < 0) first_sda = rises;
            prev_scl = cur_scl; prev_sda = cur_sda; prev_oe = scl_oe; primed = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int m, input int s, input int s_at, input bit poke);
        int n, c, exp_c, busy_bad;
        bit first_ok;
        n = (m + 1 < P) ? m + 1 : P;
        exp_c = 2 * n * H + 4 * H + s + 1;
        @(posedge clk); #1;
        cfg_m = m; cfg_s = s; cfg_at = s_at;
        mon_active = 1'b1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        c = 0; busy_bad = 0; first_ok = 0;
        forever begin
            @(negedge clk);
            c++;
            if (!busy) busy_bad++;
            if (c == 1) first_ok = busy && scl_oe;
            if (poke && c == 20) start = 1'b1;
            if (poke && c == 21) start = 1'b0;
            if (done || c > 2000) break;
        end
        chk(first_ok, "R2 busy and SCL low one cycle after start", int'(first_ok), 1);
        chk(c == exp_c, "R8 done cycle (R5 R6 R4 R9 via pulse count)", c, exp_c);
        chk(busy_bad == 0, "R8 busy held until done", busy_bad, 0);
        @(negedge clk);
        chk(!done && !busy, "R8 single done then idle", int'(done) + int'(busy), 0);
        #1;
        chk(rises == n + 1, "R5 R6 SCL rises (pulses plus STOP)", rises, n + 1);
        chk(first_sda == n, "R3 SDA untouched during train", first_sda, n);
        chk(bad_low == 0, "R3 low half length", bad_low, 0);
        chk(starts == 0, "R7 no START condition", starts, 0);
        chk(stops == ((m <= P) ? 1 : 0), "R7 STOP condition on bus", stops, (m <= P) ? 1 : 0);
        mon_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state released",
            int'(scl_oe) + int'(sda_oe) + int'(busy) + int'(done), 0);
        // sweep the stuck depth across the whole range (R5, R6)
        for (int m = 0; m <= P + 1; m++) run(m, 0, 0, 1'b0);
        // clock stretching on first and on last pulse (R4)
        run(P, 3, 1, 1'b0);
        run(2, 5, 3, 1'b0);
        run(P, 7, P, 1'b0);
        // start pulsed mid-sequence is ignored (R9)
        run(P, 0, 0, 1'b1);
        run(4, 0, 0, 1'b1);
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy, "R1 idle after all runs",
            int'(scl_oe) + int'(sda_oe) + int'(busy), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule